// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that finishes one instruction on every rising clock edge. It runs nine instructions: word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and an absolute jump. A single combinational path decodes the instruction word and reads the register operands. It then computes in the ALU, accesses data memory and selects the next program counter. At the clock edge the PC, the register file and data memory are updated together.

Instruction memory and data memory sit inside the core. Both are word arrays indexed by bits [AW+1:2] of a byte address. While reset is held, a load port fills either memory. Two observation ports read any register and any data word, so the architectural state can be compared with a model after a program has run.

Top module: `sc_core`

## Requirements
- R1: The opcode is taken from bits 31-26. Source register A is in bits 25-21, source register B in bits 20-16, the R-format destination in bits 15-11, the function code in bits 5-0 and the 16-bit immediate in bits 15-0. Opcodes are 0x00 for register-format, 0x23 for load, 0x2B for store, 0x04 for branch-if-equal and 0x02 for jump.
- R2: When rst is high at a clock edge, the PC and all 32 registers become 0 at that edge.
- R3: Every instruction other than a taken branch or a jump moves the PC to PC+4 at the next edge.
- R4: An opcode-0x00 instruction writes the register named in bits 15-11. The value written depends on the function code: 0x20 gives A+B, 0x22 gives A-B, 0x24 gives A AND B, 0x25 gives A OR B, and 0x2A gives 1 if A is less than B as signed numbers, otherwise 0.
- R5: A load reads the data word at address A + sign-extended immediate and writes it to the register named in bits 20-16.
- R6: A store writes register B to the data word at address A + sign-extended immediate and changes no register.
- R7: Branch-if-equal with A equal to B moves the PC to PC+4 + (sign-extended immediate << 2). Otherwise the PC moves to PC+4. Backward offsets are allowed.
- R8: A jump moves the PC to {PC+4 bits 31-28, instruction bits 25-0, 2'b00}.
- R9: Register 0 always reads 0, and writes to it are dropped.
- R10: The load port writes instruction memory (ld_sel=0) or data memory (ld_sel=1) at word index ld_addr only while rst is high. While rst is low it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | AW | Load word index |
| ld_data | input | 32 | Load word value |
| dbg_reg_sel | input | 5 | Register to observe |
| dbg_reg_val | output | 32 | Value of the observed register |
| dbg_mem_addr | input | AW | Data memory word index to observe |
| dbg_mem_val | output | 32 | Value of the observed data word |
| pc_out | output | 32 | Current program counter |

## Verification
The checker assumes that the program lives entirely inside instruction memory and that every fetched word is defined. It also assumes that reset is asserted before the first edge. The stimulus keeps within these limits by filling every instruction slot the program reaches during reset. The program ends in a branch to itself, so execution never runs past the loaded words. Loaded and stored addresses are word-aligned and fall inside data memory, because the properties do not cover memory index aliasing.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RIDX  = $clog2(NREGS);

    typedef enum logic [5:0] {
        OP_RTYPE = 6'h00,
        OP_JUMP  = 6'h02,
        OP_BEQ   = 6'h04,
        OP_LOAD  = 6'h23,
        OP_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    typedef struct packed {
        logic    reg_dst;
        logic    alu_src;
        logic    branch;
        logic    jump;
        logic    mem_rd;
        logic    mem_we;
        logic    reg_we;
        logic    mem_to_reg;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  instr_t  iw,
    output ctrl_t   ctl,
    output alu_fn_e alu_fn
);

    always_comb begin
        ctl = '{default: '0, alu_op: AOP_ADD};
        case (iw.op)
            OP_RTYPE: begin
                ctl.reg_dst = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.alu_op  = AOP_FUNCT;
            end
            OP_LOAD: begin
                ctl.alu_src    = 1'b1;
                ctl.mem_rd     = 1'b1;
                ctl.reg_we     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            OP_STORE: begin
                ctl.alu_src = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = AOP_SUB;
            end
            OP_JUMP: ctl.jump = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        case (ctl.alu_op)
            AOP_SUB:   alu_fn = ALU_SUB;
            AOP_FUNCT: begin
                case (iw.funct)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default:   alu_fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] ra,
    input  logic [RIDX-1:0] rb,
    input  logic [RIDX-1:0] rc,
    output logic [XLEN-1:0] da,
    output logic [XLEN-1:0] db,
    output logic [XLEN-1:0] dc,
    input  logic            we,
    input  logic [RIDX-1:0] wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign da = (ra == '0) ? '0 : regs[ra];
    assign db = (rb == '0) ? '0 : regs[rb];
    assign dc = (rc == '0) ? '0 : regs[rc];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter  int MEM_WORDS = 64,
    localparam int AW        = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_sel,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RIDX-1:0] dbg_reg_sel,
    output logic [XLEN-1:0] dbg_reg_val,
    input  logic [AW-1:0]   dbg_mem_addr,
    output logic [XLEN-1:0] dbg_mem_val,
    output logic [XLEN-1:0] pc_out
);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
    logic [XLEN-1:0] instr, imm, rs_val, rt_val, alu_b, alu_y, rdata, wb_data;
    logic [RIDX-1:0] wr_idx;
    logic [AW-1:0]   d_idx;
    logic            alu_zero;
    instr_t          iw;
    ctrl_t           ctl;
    alu_fn_e         alu_fn;

    // Fetch
    assign instr = imem[pc_q[AW+1:2]];
    assign iw    = instr_t'(instr);

    sc_decoder i_dec (
        .iw     (iw),
        .ctl    (ctl),
        .alu_fn (alu_fn)
    );

    assign wr_idx = ctl.reg_dst ? iw.rd : iw.rt;

    sc_regfile i_rf (
        .clk (clk),
        .rst (rst),
        .ra  (iw.rs),
        .rb  (iw.rt),
        .rc  (dbg_reg_sel),
        .da  (rs_val),
        .db  (rt_val),
        .dc  (dbg_reg_val),
        .we  (ctl.reg_we & ~rst),
        .wa  (wr_idx),
        .wd  (wb_data)
    );

    assign imm   = sext16(instr[15:0]);
    assign alu_b = ctl.alu_src ? imm : rt_val;

    sc_alu i_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory access and write-back selection
    assign d_idx   = alu_y[AW+1:2];
    assign rdata   = ctl.mem_rd ? dmem[d_idx] : '0;
    assign wb_data = ctl.mem_to_reg ? rdata : alu_y;

    always_ff @(posedge clk) begin
        if (rst && ld_we && ld_sel)
            dmem[ld_addr] <= ld_data;
        else if (!rst && ctl.mem_we)
            dmem[d_idx] <= rt_val;
    end

    always_ff @(posedge clk) begin
        if (rst && ld_we && !ld_sel)
            imem[ld_addr] <= ld_data;
    end

    // Next-PC selection
    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.jump)                    pc_next = j_tgt;
        else if (ctl.branch && alu_zero) pc_next = br_tgt;
        else                             pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_out      = pc_q;
    assign dbg_mem_val = dmem[dbg_mem_addr];

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            reg_we,
    input logic            mem_we
);

    logic [5:0]      op;
    logic [XLEN-1:0] seq_pc, taken_pc, jmp_pc;

    assign op       = instr[31:26];
    assign seq_pc   = pc + 32'd4;
    assign taken_pc = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign jmp_pc   = {seq_pc[31:28], instr[25:0], 2'b00};

    // R2
    pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc == '0);

    // R3
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (op != 6'h04 && op != 6'h02) |=> pc == $past(seq_pc));

    // R7
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h04 && rs_val == rt_val) |=> pc == $past(taken_pc));

    // R7
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h04 && rs_val != rt_val) |=> pc == $past(seq_pc));

    // R8
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        op == 6'h02 |=> pc == $past(jmp_pc));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        instr[25:21] == 5'd0 |-> rs_val == '0);

    // R6
    store_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        op == 6'h2B |-> (mem_we && !reg_we));

endmodule

bind sc_core sc_core_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .reg_we (ctl.reg_we),
    .mem_we (ctl.mem_we)
);

// File: tb/test_sc_core.sv
module test_sc_core;

    localparam int MW = 64;
    localparam int AW = $clog2(MW);

    typedef struct packed {
        logic [31:0] pc;
        logic [4:0]  rsel;
        logic [31:0] val;
    } row_t;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] off);
        return {op, 5'(rs), 5'(rt), off};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    localparam logic [31:0] PROG [22] = '{
        enc_i(6'h23, 0, 1, 16'd0),      // 0
        enc_i(6'h23, 0, 2, 16'd4),      // 4
        enc_i(6'h23, 0, 3, 16'd8),      // 8
        enc_r(1, 2, 4, 6'h20),          // 12
        enc_r(1, 2, 5, 6'h22),          // 16
        enc_r(1, 2, 6, 6'h24),          // 20
        enc_r(1, 2, 7, 6'h25),          // 24
        enc_r(3, 1, 8, 6'h2A),          // 28
        enc_r(1, 3, 9, 6'h2A),          // 32
        enc_i(6'h2B, 0, 4, 16'd16),     // 36
        enc_i(6'h23, 0, 10, 16'd16),    // 40
        enc_r(1, 2, 0, 6'h20),          // 44
        enc_i(6'h04, 1, 2, 16'd5),      // 48 not taken
        enc_i(6'h04, 4, 10, 16'd2),     // 52 taken -> 64
        enc_r(1, 1, 11, 6'h20),         // 56 skipped
        enc_r(2, 2, 11, 6'h20),         // 60 skipped
        enc_j(26'd20),                  // 64 -> 80
        enc_r(1, 1, 12, 6'h20),         // 68 skipped
        enc_r(1, 1, 12, 6'h20),         // 72 skipped
        enc_r(1, 1, 12, 6'h20),         // 76 skipped
        enc_i(6'h23, 4, 13, 16'hFFFC),  // 80 negative offset
        enc_i(6'h04, 0, 0, 16'hFFFF)    // 84 branch to self
    };

    localparam logic [31:0] DATA [4] = '{32'd5, 32'd7, 32'hFFFF_FFFD, 32'h8000_0000};

    localparam row_t TRACE [18] = '{
        '{32'd0,  5'd1,  32'd5},
        '{32'd4,  5'd2,  32'd7},
        '{32'd8,  5'd3,  32'hFFFF_FFFD},
        '{32'd12, 5'd4,  32'd12},
        '{32'd16, 5'd5,  32'hFFFF_FFFE},
        '{32'd20, 5'd6,  32'd5},
        '{32'd24, 5'd7,  32'd7},
        '{32'd28, 5'd8,  32'd1},
        '{32'd32, 5'd9,  32'd0},
        '{32'd36, 5'd4,  32'd12},
        '{32'd40, 5'd10, 32'd12},
        '{32'd44, 5'd0,  32'd0},
        '{32'd48, 5'd0,  32'd0},
        '{32'd52, 5'd0,  32'd0},
        '{32'd64, 5'd11, 32'd0},
        '{32'd80, 5'd13, 32'hFFFF_FFFD},
        '{32'd84, 5'd12, 32'd0},
        '{32'd84, 5'd0,  32'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic          ld_sel = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [4:0]    dbg_reg_sel = '0;
    logic [31:0]   dbg_reg_val;
    logic [AW-1:0] dbg_mem_addr = '0;
    logic [31:0]   dbg_mem_val;
    logic [31:0]   pc_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_core #(.MEM_WORDS(MW)) i_sc_core (
        .clk          (clk),
        .rst          (rst),
        .ld_we        (ld_we),
        .ld_sel       (ld_sel),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_val  (dbg_reg_val),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_val  (dbg_mem_val),
        .pc_out       (pc_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R2: reset state
        check("R2 pc in reset", pc_out, 32'd0);
        dbg_reg_sel = 5'd5;
        check("R2 reg cleared", dbg_reg_val, 32'd0);

        // R10: load program and data during reset
        ld_we = 1'b1;
        ld_sel = 1'b0;
        for (int i = 0; i < 22; i++) begin
            ld_addr = AW'(i);
            ld_data = PROG[i];
            @(negedge clk);
        end
        ld_sel = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ld_addr = AW'(i);
            ld_data = DATA[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        rst = 1'b0;

        // R1 R3 R4 R5 R6 R7 R8 R9: executed trace
        for (int k = 0; k < 18; k++) begin
            check("R3/R7/R8 pc", pc_out, TRACE[k].pc);
            dbg_reg_sel = TRACE[k].rsel;
            @(negedge clk);
            check("R1/R4/R5/R9 reg", dbg_reg_val, TRACE[k].val);
        end

        // R6: stored word and untouched neighbour
        dbg_mem_addr = AW'(4);
        check("R6 stored word", dbg_mem_val, 32'd12);
        dbg_mem_addr = AW'(0);
        check("R6 other word", dbg_mem_val, 32'd5);

        // R10: load port ignored out of reset
        ld_we = 1'b1;
        ld_sel = 1'b1;
        ld_addr = AW'(0);
        ld_data = 32'h99;
        @(negedge clk);
        ld_we = 1'b0;
        check("R10 load ignored", dbg_mem_val, 32'd5);

        // R2: reset in the middle of execution
        rst = 1'b1;
        @(negedge clk);
        check("R2 pc after reset", pc_out, 32'd0);
        dbg_reg_sel = 5'd1;
        check("R2 reg after reset", dbg_reg_val, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule